// File: doc/BRIEF.md
# Quadrature Encoder and Edge Counter

This block counts edges on two external inputs and keeps the result in a register that a host reads and writes over a small strobe bus. The bus has a write strobe, a read strobe, an address and a data word. The block has two ways of counting. In edge-count mode it counts up on the selected edges of input 1 and takes no notice of input 2. In quadrature mode it treats the two inputs as a phase pair and counts up or down depending on which input leads.

An edge-polarity field picks which edges count. Rising only, falling only, or both. In quadrature mode this sets the resolution: a single edge type gives two counts per input cycle, and both edges give four. The count wraps at a programmable ceiling. The ceiling and compare registers can only be written while the block is enabled. Each accepted write raises a completion flag, and the host clears that flag by writing a one to the matching bit of the acknowledge register.

The address map is: 0 control, 1 mode, 2 ceiling, 3 compare, 4 flags, 5 flag acknowledge, 6 count. Reads are registered. The data appears on `rd_data` on the clock edge that samples `rd_en` and holds until the next read.

Top module: `lpq_counter`

## Requirements
- R1: After reset the count reads 0, the flags register (address 4) reads 0, the control register (address 0, bit 0 enable, bit 1 run) reads 0, and the ceiling (address 2) reads 16'hFFFF.
- R2: The polarity field (mode register bits 3:2) selects edges: code 0 is rising, code 1 is falling, code 2 is both. A write that carries code 3 leaves the stored polarity unchanged.
- R3: In edge-count mode (mode bit 0 = 0, bit 1 = 1) the count goes up by one on each selected edge of input 1. Edges on input 2 do not change it.
- R4: In quadrature mode (mode bit 0 = 1) with both-edge polarity, every legal step of the pair {in1,in2} counts once. The sequence 00→01→11→10 counts up and its reverse counts down, so one input cycle gives four counts.
- R5: In quadrature mode with rising or falling polarity, only steps in which an input makes the selected edge count, so one input cycle gives two counts.
- R6: In quadrature mode a step in which both inputs change in the same sample does not change the count.
- R7: Writes to the ceiling (address 2) and compare (address 3) registers take effect only while enable is set. An accepted ceiling write sets flag bit 0 and an accepted compare write sets flag bit 1.
- R8: Each flag stays set until the host writes a 1 to the same bit of the acknowledge register (address 5). Writing 0 to a bit leaves that flag as it is.
- R9: The run bit is only set by a control write that has bits 0 and 1 both set while enable is already set. The count changes only while enable and run are both set.
- R10: When counting up from a value at or above the ceiling, the count goes to 0. When counting down from 0, the count goes to the ceiling.
- R11: Clearing enable forces the count to 0 and clears run. Mode register writes are ignored while enable is set. The prescaler field (mode bits 6:4) always reads 0.
- R12: With mode bits 0 and 1 both 0, no input edge changes the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in1 | input | 1 | Counting input 1 / quadrature phase 1 (asynchronous) |
| in2 | input | 1 | Quadrature phase 2 (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench runs every polarity code in both modes and in both quadrature directions. For each run it drives enough input cycles to wrap past a ceiling of 9 and compares the count with the product of cycles and counts per cycle, taken modulo 10. A decoder with the resolution wrong lands on a different residue, and one that reverses direction gives the complement. A single down step from 0 must land on 9, so a design that wraps to the all-ones value shows up at once.

The bench also feeds the decoder a jump of both inputs at once, which must leave the count untouched. It toggles input 2 in edge-count mode and sends a start on the same write as enable. Each of these is a place where a loose design would count when it should not. Flags are checked after a partial acknowledge, and configuration writes are checked while enabled, so any flag or field that clears or changes too freely is caught.

// File: rtl/lpq_pkg.sv
package lpq_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] A_MODE  = 3'd1;
    localparam logic [REG_AW-1:0] A_CEIL  = 3'd2;
    localparam logic [REG_AW-1:0] A_CMP   = 3'd3;
    localparam logic [REG_AW-1:0] A_FLAGS = 3'd4;
    localparam logic [REG_AW-1:0] A_ACK   = 3'd5;
    localparam logic [REG_AW-1:0] A_COUNT = 3'd6;

    typedef enum logic [1:0] {
        POL_RISE = 2'd0,
        POL_FALL = 2'd1,
        POL_BOTH = 2'd2,
        POL_BAD  = 2'd3
    } pol_e;

    // True when the edge kind observed matches the selected polarity.
    function automatic logic edge_hit(pol_e pol, logic rose, logic fell);
        case (pol)
            POL_RISE: return rose;
            POL_FALL: return fell;
            POL_BOTH: return rose | fell;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lpq_sync.sv
module lpq_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign dout[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/lpq_step_decode.sv
module lpq_step_decode
    import lpq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pair,      // {in1, in2} after synchronization
    input  logic       quad_sel,
    input  logic       ext_sel,
    input  pol_e       pol,
    output logic       step_up,
    output logic       step_dn
);
    logic [1:0] prev_d, prev_q;
    logic       p1_rise, p1_fall, p2_rise, p2_fall;
    logic       fwd, rev;

    always_comb begin
        prev_d  = pair;
        p1_rise = ~prev_q[1] &  pair[1];
        p1_fall =  prev_q[1] & ~pair[1];
        p2_rise = ~prev_q[0] &  pair[0];
        p2_fall =  prev_q[0] & ~pair[0];

        fwd = (prev_q == 2'b00 && pair == 2'b01) ||
              (prev_q == 2'b01 && pair == 2'b11) ||
              (prev_q == 2'b11 && pair == 2'b10) ||
              (prev_q == 2'b10 && pair == 2'b00);
        rev = (prev_q == 2'b01 && pair == 2'b00) ||
              (prev_q == 2'b11 && pair == 2'b01) ||
              (prev_q == 2'b10 && pair == 2'b11) ||
              (prev_q == 2'b00 && pair == 2'b10);

        if (quad_sel) begin
            step_up = fwd & edge_hit(pol, p1_rise | p2_rise, p1_fall | p2_fall);
            step_dn = rev & edge_hit(pol, p1_rise | p2_rise, p1_fall | p2_fall);
        end else begin
            step_up = ext_sel & edge_hit(pol, p1_rise, p1_fall);
            step_dn = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b00;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/lpq_wrap_counter.sv
module lpq_wrap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             up,
    input  logic             dn,
    input  logic [CNT_W-1:0] ceil,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (up) begin
            cnt_d = (cnt_q >= ceil) ? '0 : cnt_q + 1'b1;
        end else if (dn) begin
            cnt_d = (cnt_q == '0) ? ceil : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/lpq_counter.sv
module lpq_counter
    import lpq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in1,
    input  logic              in2,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] CEIL_RST = {CNT_W{1'b1}};

    typedef struct packed {
        logic              en;
        logic              run;
        logic              quad;
        logic              ext;
        pol_e              pol;
        logic [CNT_W-1:0]  ceil;
        logic [CNT_W-1:0]  cmp;
        logic              ceil_ok;
        logic              cmp_ok;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t            st_d, st_q;
    logic [1:0]       pair;
    logic             step_up, step_dn;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] rd_mux;

    // Plain views of state for the bound checker.
    logic             en_w, run_w, ceil_ok_w, cmp_ok_w;
    logic [CNT_W-1:0] ceil_w;
    assign en_w      = st_q.en;
    assign run_w     = st_q.en & st_q.run;
    assign ceil_ok_w = st_q.ceil_ok;
    assign cmp_ok_w  = st_q.cmp_ok;
    assign ceil_w    = st_q.ceil;

    lpq_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({in1, in2}),
        .dout  (pair)
    );

    lpq_step_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair     (pair),
        .quad_sel (st_q.quad),
        .ext_sel  (st_q.ext),
        .pol      (st_q.pol),
        .step_up  (step_up),
        .step_dn  (step_dn)
    );

    lpq_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (~st_q.en),
        .up    (step_up & run_w),
        .dn    (step_dn & run_w),
        .ceil  (st_q.ceil),
        .cnt   (cnt)
    );

    always_comb begin
        rd_mux = '0;
        case (addr)
            A_CTRL:  rd_mux[1:0] = {st_q.run, st_q.en};
            A_MODE:  rd_mux[3:0] = {st_q.pol, st_q.ext, st_q.quad};
            A_CEIL:  rd_mux[CNT_W-1:0] = st_q.ceil;
            A_CMP:   rd_mux[CNT_W-1:0] = st_q.cmp;
            A_FLAGS: rd_mux[1:0] = {st_q.cmp_ok, st_q.ceil_ok};
            A_COUNT: rd_mux[CNT_W-1:0] = cnt;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    st_d.en  = wr_data[0];
                    st_d.run = wr_data[0] & wr_data[1] & st_q.en;
                end
                A_MODE: begin
                    if (!st_q.en) begin
                        st_d.quad = wr_data[0];
                        st_d.ext  = wr_data[1];
                        if (pol_e'(wr_data[3:2]) != POL_BAD) st_d.pol = pol_e'(wr_data[3:2]);
                    end
                end
                A_CEIL: begin
                    if (st_q.en) begin
                        st_d.ceil    = wr_data[CNT_W-1:0];
                        st_d.ceil_ok = 1'b1;
                    end
                end
                A_CMP: begin
                    if (st_q.en) begin
                        st_d.cmp    = wr_data[CNT_W-1:0];
                        st_d.cmp_ok = 1'b1;
                    end
                end
                A_ACK: begin
                    st_d.ceil_ok = st_q.ceil_ok & ~wr_data[0];
                    st_d.cmp_ok  = st_q.cmp_ok  & ~wr_data[1];
                end
                default: ;
            endcase
        end
        if (rd_en) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pol  <= POL_RISE;
            st_q.ceil <= CEIL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;
endmodule

// File: rtl/lpq_counter_chk.sv
module lpq_counter_chk #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              run,
    input logic              up,
    input logic              dn,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  ceil,
    input logic              ceil_ok,
    input logic              cmp_ok,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic [DATA_W-1:0] wr_data
);
    p_disabled_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    p_up_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && up && cnt >= ceil) |=> (cnt == '0));

    p_down_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dn && cnt == '0) |=> (cnt == $past(ceil)));

    p_hold_unstarted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !run) |=> $stable(cnt));

    p_one_direction_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

    p_ceil_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ceil_ok && !(wr_en && addr == 3'd5 && wr_data[0])) |=> ceil_ok);

    p_cmp_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_ok && !(wr_en && addr == 3'd5 && wr_data[1])) |=> cmp_ok);

    p_flag_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ceil_ok) |-> $past(en));
endmodule

bind lpq_counter lpq_counter_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_w),
    .run     (run_w),
    .up      (step_up),
    .dn      (step_dn),
    .cnt     (cnt),
    .ceil    (ceil_w),
    .ceil_ok (ceil_ok_w),
    .cmp_ok  (cmp_ok_w),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data)
);

// File: tb/lpq_counter_bench.sv
module lpq_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in1 = 1'b0, in2 = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int tests = 0;
    int fails = 0;
    localparam int MODV = 10;   // ceiling 9

    always #4 clk = ~clk;

    lpq_counter u_lpq_counter (
        .clk(clk), .rst_n(rst_n), .in1(in1), .in2(in2),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic set_in(input logic a, input logic b);
        @(negedge clk);
        in1 = a; in2 = b;
        repeat (5) @(negedge clk);
    endtask

    task automatic setup(input logic quad, input logic ext, input logic [1:0] pol, input logic start);
        wr(3'd0, 16'h0);
        wr(3'd1, {12'h0, pol, ext, quad});
        wr(3'd0, 16'h1);
        if (start) wr(3'd0, 16'h3);
    endtask

    task automatic quad_cycle(input logic down);
        if (!down) begin
            set_in(0, 1); set_in(1, 1); set_in(1, 0); set_in(0, 0);
        end else begin
            set_in(1, 0); set_in(1, 1); set_in(0, 1); set_in(0, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd6, v); chk("R1 count", v, 16'h0);
        rd(3'd4, v); chk("R1 flags", v, 16'h0);
        rd(3'd0, v); chk("R1 ctrl", v, 16'h0);
        rd(3'd2, v); chk("R1 ceiling", v, 16'hFFFF);

        // R7 ceiling write while disabled is dropped
        wr(3'd2, 16'd9);
        rd(3'd2, v); chk("R7 ceil disabled", v, 16'hFFFF);
        rd(3'd4, v); chk("R7 no flag disabled", v, 16'h0);

        // R9 run requested together with enable from disabled is dropped
        wr(3'd0, 16'h3);
        rd(3'd0, v); chk("R9 start ignored", v, 16'h1);

        // R7 / R8 flags
        wr(3'd2, 16'd9);
        rd(3'd4, v); chk("R7 ceil flag", v, 16'h1);
        rd(3'd2, v); chk("R7 ceil value", v, 16'd9);
        wr(3'd3, 16'd5);
        rd(3'd4, v); chk("R7 cmp flag", v, 16'h3);
        wr(3'd5, 16'h0);
        rd(3'd4, v); chk("R8 zero ack", v, 16'h3);
        wr(3'd5, 16'h1);
        rd(3'd4, v); chk("R8 partial ack", v, 16'h2);
        repeat (4) @(negedge clk);
        rd(3'd4, v); chk("R8 flag held", v, 16'h2);
        wr(3'd5, 16'h2);
        rd(3'd4, v); chk("R8 full ack", v, 16'h0);

        // R9 enabled but not started: no count
        setup(0, 1, 2'd2, 0);
        for (int i = 0; i < 3; i++) begin set_in(1, 0); set_in(0, 0); end
        rd(3'd6, v); chk("R9 not started", v, 16'h0);
        wr(3'd0, 16'h3);
        for (int i = 0; i < 3; i++) begin set_in(1, 0); set_in(0, 0); end
        rd(3'd6, v); chk("R9 started", v, 16'd6);

        // R3 / R2 edge-count sweep over polarity codes
        for (int p = 0; p < 3; p++) begin
            int per;
            setup(0, 1, 2'(p), 1);
            for (int i = 0; i < 13; i++) begin
                set_in(1, 0); set_in(0, 0); set_in(0, 1); set_in(0, 0);
            end
            per = (p == 2) ? 2 : 1;
            rd(3'd6, v); chk($sformatf("R3 R2 count pol=%0d", p), v, 16'((13 * per) % MODV));
        end

        // R3 input 2 alone does nothing in edge-count mode
        setup(0, 1, 2'd2, 1);
        for (int i = 0; i < 6; i++) begin set_in(0, 1); set_in(0, 0); end
        rd(3'd6, v); chk("R3 in2 ignored", v, 16'h0);

        // R4 / R5 / R10 quadrature sweep
        for (int p = 0; p < 3; p++) begin
            for (int d = 0; d < 2; d++) begin
                int per, tot;
                setup(1, 0, 2'(p), 1);
                for (int i = 0; i < 7; i++) quad_cycle(d[0]);
                per = (p == 2) ? 4 : 2;
                tot = (7 * per) % MODV;
                if (d == 1) tot = (MODV - tot) % MODV;
                rd(3'd6, v);
                chk($sformatf("%s quad pol=%0d dir=%0d", (p == 2) ? "R4" : "R5", p, d), v, 16'(tot));
            end
        end

        // R10 single down step from 0 lands on ceiling
        setup(1, 0, 2'd2, 1);
        set_in(1, 0);
        rd(3'd6, v); chk("R10 down wrap", v, 16'd9);
        set_in(0, 0);

        // R6 simultaneous change of both inputs
        setup(1, 0, 2'd2, 1);
        set_in(1, 1);
        rd(3'd6, v); chk("R6 jump 00-11", v, 16'h0);
        set_in(0, 0);
        rd(3'd6, v); chk("R6 jump 11-00", v, 16'h0);
        set_in(0, 1);
        rd(3'd6, v); chk("R6 legal after jump", v, 16'h1);

        // R11 mode write while enabled is ignored; disable clears count
        wr(3'd1, 16'h0006);
        rd(3'd1, v); chk("R11 mode locked", v, 16'h0009);
        wr(3'd0, 16'h0);
        rd(3'd6, v); chk("R11 disable clears", v, 16'h0);
        rd(3'd0, v); chk("R11 run cleared", v, 16'h0);
        set_in(0, 0);

        // R11 prescaler bits read zero; R2 code 3 keeps polarity
        wr(3'd1, 16'h0075);
        rd(3'd1, v); chk("R11 prescaler zero", v, 16'h0005);
        wr(3'd1, 16'h000E);
        rd(3'd1, v); chk("R2 code 3 keeps pol", v, 16'h0006);

        // R12 no source selected
        setup(0, 0, 2'd2, 1);
        for (int i = 0; i < 5; i++) begin set_in(1, 0); set_in(0, 0); end
        rd(3'd6, v); chk("R12 no source", v, 16'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule